// File: doc/BRIEF.md
# Eight-way pseudo-LRU cache tag controller

This block keeps the tags, valid bits, dirty bits and replacement state for a 32 KB data cache built as 8 ways of 32-byte lines, which gives 128 sets. A core lookup presents a line address, a read/write flag, a per-access write-policy bit and a transient hint. In the same cycle the block reports whether the line is present and in which way, which way would be replaced, whether that victim holds modified data, and whether the write has to be passed on to the next memory level. A miss allocates the victim way at the clock edge, so the refill logic outside the block can fill the data array in that way.

Replacement uses a 7-bit binary tree per set. Invalid ways are always used first, lowest-numbered first. An ordinary access steers the tree away from the touched way. A transient access steers it toward that way, so the line is the first one replaced.

A second port serves coherence snoops from a duplicate copy of the tags. It runs in parallel with the core port. A snoop that hits can invalidate the line, and it clears the valid bit in both tag copies in the same cycle.

Top module: `plru8_tag_ctrl`

## Requirements
- R1: After reset every line is invalid, every dirty bit is clear and every tree is zero. A lookup then misses and reports victim way 0.
- R2: The line address carries the set index in bits 11:5 and the tag in bits 31:12. Lines with equal tags but different indices are distinct. Lines in one set whose tags differ in any bit, including bit 31, are distinct.
- R3: `rsp_hit` and `rsp_way` are valid combinationally in the cycle of the lookup. A miss installs the tag in the reported victim way at the clock edge, so a lookup of the same line in the next cycle hits in that way.
- R4: If the addressed set has an invalid way, the victim is the lowest-numbered invalid way.
- R5: Tree encoding: node 0 selects way bit 2 (1 means the upper half). Node 1+b2 selects bit 1. Node 3+2*b2+b1 selects bit 0. With all ways valid the victim is found by walking the tree. A normal access sets each node on the path to the opposite of the accessed way's bit.
- R6: A transient access sets each node on the path equal to the accessed way's bit. With all ways valid, the next victim in that set is the way just touched.
- R7: `rsp_forward` is high exactly when a valid lookup is a write with `req_wt`=1. A copy-back write (`req_wt`=0) marks the line dirty, on a hit and on an allocation. A write-through write or a read allocates a clean line and leaves the dirty bit of a hit line unchanged.
- R8: `rsp_evict_dirty` is high on a miss whose victim way is valid and dirty.
- R9: Snoops are answered in the same cycle from the duplicate tag copy, independently of any core lookup. `snp_hit` and `snp_way` are reported the same way the core port reports a hit.
- R10: A snoop hit with `snp_inval`=1 clears the line's valid and dirty bits in both tag copies. If a core miss allocates the same set and way in that cycle, the allocation takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core lookup present |
| req_addr | input | 27 | Core line address, bits 31:5 |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wt | input | 1 | Page attribute: 1 = write-through, 0 = copy-back |
| req_transient | input | 1 | Transient hint for the replacement update |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 3 | Way that hit |
| rsp_victim | output | 3 | Way chosen for replacement |
| rsp_evict_dirty | output | 1 | Miss whose victim holds modified data |
| rsp_forward | output | 1 | Write must be sent to the next level |
| snp_valid | input | 1 | Snoop lookup present |
| snp_addr | input | 27 | Snoop line address, bits 31:5 |
| snp_inval | input | 1 | Invalidate the line on a snoop hit |
| snp_hit | output | 1 | Snoop hit in the duplicate tags |
| snp_way | output | 3 | Way that the snoop hit |

## Verification
The hardest state to reach is a completely full set whose tree has been steered by a known sequence of ordinary and transient touches. Only then does the victim depend on the tree rather than on the invalid-first rule. The bench fills chosen sets with eight distinct tags, touches specific ways, and then forces misses so the tree's choice and the dirty state of evicted lines are exposed at the ports. A cycle where a snoop kill and a core allocation hit the same way is set up directly. Random traffic confined to four sets and twelve tags keeps sets full and keeps snoops colliding with live lines.

// File: rtl/plru8_tag_pkg.sv
package plru8_tag_pkg;

    localparam int ADDR_W      = 32;
    localparam int LINE_BYTES  = 32;
    localparam int CACHE_BYTES = 32768;
    localparam int WAYS        = 8;
    localparam int OFS_W       = $clog2(LINE_BYTES);
    localparam int SETS        = CACHE_BYTES / (LINE_BYTES * WAYS);
    localparam int IDX_W       = $clog2(SETS);
    localparam int TAG_W       = ADDR_W - IDX_W - OFS_W;
    localparam int WAY_W       = $clog2(WAYS);
    localparam int TREE_W      = WAYS - 1;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [TREE_W-1:0] tree_t;

    typedef struct packed {
        logic found;
        way_t way;
    } pick_t;

    // lowest set bit of a way vector
    function automatic pick_t lowest_way(input logic [WAYS-1:0] vec);
        pick_t r;
        r = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vec[w]) begin
                r.found = 1'b1;
                r.way   = way_t'(w);
            end
        end
        return r;
    endfunction

    // walk the tree from the root, one way bit per level
    function automatic way_t tree_walk(input tree_t t);
        way_t w;
        int   node;
        w    = '0;
        node = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            w[WAY_W-1-lvl] = t[node];
            node = 2 * node + 1 + int'(t[node]);
        end
        return w;
    endfunction

    // normal touch points away from the way, transient touch points at it
    function automatic tree_t tree_touch(input tree_t t, input way_t w, input logic transient);
        tree_t r;
        int    node;
        logic  b;
        r    = t;
        node = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            b       = w[WAY_W-1-lvl];
            r[node] = transient ? b : ~b;
            node    = 2 * node + 1 + int'(b);
        end
        return r;
    endfunction

endpackage

// File: rtl/plru8_tag_bank.sv
module plru8_tag_bank #(
    parameter int SETS  = 128,
    parameter int WAYS  = 8,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [IDX_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]             rd_valid,
    input  logic                        kill_en,
    input  logic [IDX_W-1:0]            kill_set,
    input  logic [WAY_W-1:0]            kill_way,
    input  logic                        fill_en,
    input  logic [IDX_W-1:0]            fill_set,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [TAG_W-1:0]            fill_tag
);

    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            valid_q [SETS];

    assign rd_tag   = tag_q[rd_set];
    assign rd_valid = valid_q[rd_set];

    // kill first, fill last: a same-cycle fill of the same way wins
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
            end
        end else begin
            if (kill_en) valid_q[kill_set][kill_way] <= 1'b0;
            if (fill_en) valid_q[fill_set][fill_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
    end

endmodule

// File: rtl/plru8_line_state.sv
module plru8_line_state
    import plru8_tag_pkg::*;
#(
    parameter int SETS = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_set,
    output tree_t            rd_tree,
    output logic [WAYS-1:0]  rd_dirty,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_set,
    input  way_t             touch_way,
    input  logic             touch_transient,
    input  logic             dset_en,
    input  logic [IDX_W-1:0] dset_set,
    input  way_t             dset_way,
    input  logic             dclr_en,
    input  logic [IDX_W-1:0] dclr_set,
    input  way_t             dclr_way,
    input  logic             dnew_en,
    input  logic [IDX_W-1:0] dnew_set,
    input  way_t             dnew_way,
    input  logic             dnew_val
);

    tree_t           tree_q  [SETS];
    logic [WAYS-1:0] dirty_q [SETS];

    assign rd_tree  = tree_q[rd_set];
    assign rd_dirty = dirty_q[rd_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                tree_q[s] <= '0;
            end
        end else if (touch_en) begin
            tree_q[touch_set] <= tree_touch(tree_q[touch_set], touch_way, touch_transient);
        end
    end

    // order: mark, then snoop clear, then allocation overwrite
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                dirty_q[s] <= '0;
            end
        end else begin
            if (dset_en) dirty_q[dset_set][dset_way] <= 1'b1;
            if (dclr_en) dirty_q[dclr_set][dclr_way] <= 1'b0;
            if (dnew_en) dirty_q[dnew_set][dnew_way] <= dnew_val;
        end
    end

endmodule

// File: rtl/plru8_tag_ctrl.sv
module plru8_tag_ctrl
    import plru8_tag_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:OFS_W]   req_addr,
    input  logic                    req_write,
    input  logic                    req_wt,
    input  logic                    req_transient,
    output logic                    rsp_hit,
    output logic [WAY_W-1:0]        rsp_way,
    output logic [WAY_W-1:0]        rsp_victim,
    output logic                    rsp_evict_dirty,
    output logic                    rsp_forward,
    input  logic                    snp_valid,
    input  logic [ADDR_W-1:OFS_W]   snp_addr,
    input  logic                    snp_inval,
    output logic                    snp_hit,
    output logic [WAY_W-1:0]        snp_way
);

    idx_t req_idx, snp_idx;
    tag_t req_tag, snp_tag;

    assign req_idx = req_addr[OFS_W+IDX_W-1:OFS_W];
    assign req_tag = req_addr[ADDR_W-1:OFS_W+IDX_W];
    assign snp_idx = snp_addr[OFS_W+IDX_W-1:OFS_W];
    assign snp_tag = snp_addr[ADDR_W-1:OFS_W+IDX_W];

    logic [WAYS-1:0][TAG_W-1:0] pri_tag, dup_tag;
    logic [WAYS-1:0]            pri_valid, dup_valid;
    logic [WAYS-1:0]            pri_dirty;
    tree_t                      cur_tree;

    logic [WAYS-1:0] hit_vec, snp_vec;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign hit_vec[w] = pri_valid[w] && (pri_tag[w] == req_tag);
            assign snp_vec[w] = dup_valid[w] && (dup_tag[w] == snp_tag);
        end
    endgenerate

    pick_t hit_pick, inv_pick, snp_pick;
    way_t  victim;
    way_t  touch_way;

    assign hit_pick = lowest_way(hit_vec);
    assign inv_pick = lowest_way(~pri_valid);
    assign snp_pick = lowest_way(snp_vec);
    assign victim   = inv_pick.found ? inv_pick.way : tree_walk(cur_tree);

    logic core_hit, fill_en, mark_en, kill_en;

    assign core_hit  = req_valid && hit_pick.found;
    assign fill_en   = req_valid && !hit_pick.found;
    assign mark_en   = core_hit && req_write && !req_wt;
    assign kill_en   = snp_hit && snp_inval;
    assign touch_way = hit_pick.found ? hit_pick.way : victim;

    assign rsp_hit         = core_hit;
    assign rsp_way         = hit_pick.way;
    assign rsp_victim      = victim;
    assign rsp_evict_dirty = fill_en && pri_valid[victim] && pri_dirty[victim];
    assign rsp_forward     = req_valid && req_write && req_wt;
    assign snp_hit         = snp_valid && snp_pick.found;
    assign snp_way         = snp_pick.way;

    // primary copy, read by the core port
    plru8_tag_bank #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_pri (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (req_idx),
        .rd_tag   (pri_tag),
        .rd_valid (pri_valid),
        .kill_en  (kill_en),
        .kill_set (snp_idx),
        .kill_way (snp_way),
        .fill_en  (fill_en),
        .fill_set (req_idx),
        .fill_way (victim),
        .fill_tag (req_tag)
    );

    // duplicate copy, read by the snoop port
    plru8_tag_bank #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_dup (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (snp_idx),
        .rd_tag   (dup_tag),
        .rd_valid (dup_valid),
        .kill_en  (kill_en),
        .kill_set (snp_idx),
        .kill_way (snp_way),
        .fill_en  (fill_en),
        .fill_set (req_idx),
        .fill_way (victim),
        .fill_tag (req_tag)
    );

    plru8_line_state #(.SETS(SETS)) u_state (
        .clk             (clk),
        .rst             (rst),
        .rd_set          (req_idx),
        .rd_tree         (cur_tree),
        .rd_dirty        (pri_dirty),
        .touch_en        (req_valid),
        .touch_set       (req_idx),
        .touch_way       (touch_way),
        .touch_transient (req_transient),
        .dset_en         (mark_en),
        .dset_set        (req_idx),
        .dset_way        (hit_pick.way),
        .dclr_en         (kill_en),
        .dclr_set        (snp_idx),
        .dclr_way        (snp_way),
        .dnew_en         (fill_en),
        .dnew_set        (req_idx),
        .dnew_way        (victim),
        .dnew_val        (req_write && !req_wt)
    );

    // R3: a line lives in at most one way
    assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R3: the line allocated on a miss hits in the victim way one cycle later
    assert_fill_then_hit_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && req_valid && !rsp_hit) && req_valid && req_addr == $past(req_addr))
        |-> (rsp_hit && rsp_way == $past(rsp_victim)));

    // R5: a way touched normally is not the next victim of its set
    assert_touched_not_victim_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && req_valid && rsp_hit && !req_transient && !(snp_valid && snp_inval))
         && req_valid && req_idx == $past(req_idx))
        |-> (rsp_victim != $past(rsp_way)));

    // R9: both tag copies agree on the same line
    assert_copies_agree_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && snp_valid && req_addr == snp_addr)
        |-> (rsp_hit == snp_hit && (!rsp_hit || rsp_way == snp_way)));

    // R10: a killed line is gone unless the core re-allocated it
    assert_kill_sticks_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && snp_hit && snp_inval) && snp_valid && snp_addr == $past(snp_addr)
         && !($past(req_valid && !rsp_hit) && $past(req_addr) == snp_addr))
        |-> !snp_hit);

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_clean
            // R10: an invalid way never holds a dirty mark
            assert_invalid_clean_R10: assert property (@(posedge clk) disable iff (rst)
                !pri_valid[w] |-> !pri_dirty[w]);
        end
    endgenerate

endmodule

// File: tb/plru8_tag_ctrl_tb.sv
module plru8_tag_ctrl_tb;

    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #HALF clk = ~clk;

    logic        rv = 0, rw = 0, rwt = 0, rtr = 0, sv = 0, si = 0;
    logic [31:5] ra = '0, sa = '0;
    logic        rsp_hit, rsp_evict_dirty, rsp_forward, snp_hit;
    logic [2:0]  rsp_way, rsp_victim, snp_way;

    plru8_tag_ctrl u_dut (
        .clk(clk), .rst(rst),
        .req_valid(rv), .req_addr(ra), .req_write(rw), .req_wt(rwt), .req_transient(rtr),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_victim(rsp_victim),
        .rsp_evict_dirty(rsp_evict_dirty), .rsp_forward(rsp_forward),
        .snp_valid(sv), .snp_addr(sa), .snp_inval(si),
        .snp_hit(snp_hit), .snp_way(snp_way)
    );

    int checks = 0;
    int fails  = 0;

    bit [19:0] mtag   [128][8];
    bit        mval   [128][8];
    bit        mdirty [128][8];
    bit [6:0]  mtree  [128];

    bit o_hit, o_ed, o_fwd, o_sh;
    int o_way, o_vic, o_sw;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic int walk(input bit [6:0] t);
        int b2, b1, b0;
        b2 = t[0];
        b1 = t[1 + b2];
        b0 = t[3 + 2 * b2 + b1];
        return 4 * b2 + 2 * b1 + b0;
    endfunction

    function automatic bit [6:0] touch(input bit [6:0] t, input int w, input bit tr);
        bit [6:0] r;
        bit [2:0] wb;
        wb = w[2:0];
        r = t;
        r[0]                        = tr ? wb[2] : ~wb[2];
        r[1 + wb[2]]                = tr ? wb[1] : ~wb[1];
        r[3 + 2 * wb[2] + wb[1]]    = tr ? wb[0] : ~wb[0];
        return r;
    endfunction

    function automatic logic [31:5] mk(input int tg, input int ix);
        logic [31:5] a;
        a[31:12] = tg[19:0];
        a[11:5]  = ix[6:0];
        return a;
    endfunction

    // called just after a falling edge with inputs driven; checks, updates model
    task automatic step();
        int ix, sx, ew, ev, esw;
        bit [19:0] tg, st;
        bit eh, ed, ef, esh;
        #1;
        ix = int'(ra[11:5]); tg = ra[31:12];
        sx = int'(sa[11:5]); st = sa[31:12];
        eh = 0; ew = 0;
        for (int w = 7; w >= 0; w--) if (mval[ix][w] && mtag[ix][w] == tg) begin eh = 1; ew = w; end
        ev = -1;
        for (int w = 7; w >= 0; w--) if (!mval[ix][w]) ev = w;
        if (ev < 0) ev = walk(mtree[ix]);
        ed  = rv && !eh && mval[ix][ev] && mdirty[ix][ev];
        ef  = rv && rw && rwt;
        esh = 0; esw = 0;
        for (int w = 7; w >= 0; w--) if (sv && mval[sx][w] && mtag[sx][w] == st) begin esh = 1; esw = w; end

        o_hit = rsp_hit; o_way = int'(rsp_way); o_vic = int'(rsp_victim);
        o_ed = rsp_evict_dirty; o_fwd = rsp_forward; o_sh = snp_hit; o_sw = int'(snp_way);

        if (rv) begin
            chk(o_hit == eh, "R3 hit", o_hit, eh);
            if (eh) chk(o_way == ew, "R3 way", o_way, ew);
            chk(o_vic == ev, "R5 victim", o_vic, ev);
            chk(o_ed == ed, "R8 evict dirty", o_ed, ed);
        end
        chk(o_fwd == ef, "R7 forward", o_fwd, ef);
        chk(o_sh == esh, "R9 snoop hit", o_sh, esh);
        if (esh) chk(o_sw == esw, "R9 snoop way", o_sw, esw);

        if (rv && eh && rw && !rwt) mdirty[ix][ew] = 1;
        if (esh && si) begin mval[sx][esw] = 0; mdirty[sx][esw] = 0; end
        if (rv && !eh) begin
            mtag[ix][ev] = tg; mval[ix][ev] = 1; mdirty[ix][ev] = rw && !rwt;
        end
        if (rv) mtree[ix] = touch(mtree[ix], eh ? ew : ev, rtr);
        @(negedge clk);
    endtask

    task automatic look(input int tg, input int ix, input bit w, input bit wt, input bit tr);
        rv = 1; ra = mk(tg, ix); rw = w; rwt = wt; rtr = tr;
        sv = 0; si = 0;
        step();
    endtask

    task automatic fill_reads(input int ix, input int first_tag, input int n);
        for (int k = 0; k < n; k++) look(first_tag + k, ix, 0, 0, 0);
    endtask

    initial begin
        #(2 * HALF * 200000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: empty after reset
        look(5, 0, 0, 0, 0);
        chk(o_hit == 0, "R1 miss after reset", o_hit, 0);
        chk(o_vic == 0, "R1 victim after reset", o_vic, 0);
        // R3: allocated line hits next cycle
        look(5, 0, 0, 0, 0);
        chk(o_hit == 1 && o_way == 0, "R3 hit after fill", o_way, 0);

        // R4: invalid ways fill lowest first
        for (int k = 0; k < 8; k++) begin
            look(1 + k, 3, 0, 0, 0);
            chk(o_vic == k, "R4 invalid first", o_vic, k);
        end
        // R5: after in-order touches the tree names way 0
        look(9, 3, 0, 0, 0);
        chk(o_hit == 0 && o_vic == 0, "R5 tree victim", o_vic, 0);

        // R6: transient touch makes the way the next victim
        fill_reads(4, 1, 8);
        look(6, 4, 0, 0, 1);
        chk(o_hit == 1 && o_way == 5, "R6 transient hit", o_way, 5);
        look(20, 4, 0, 0, 0);
        chk(o_vic == 5, "R6 transient victim", o_vic, 5);

        // R8: copy-back allocation evicts dirty
        look(1, 5, 1, 0, 0);
        chk(o_fwd == 0, "R7 copy-back not forwarded", o_fwd, 0);
        fill_reads(5, 2, 7);
        look(9, 5, 0, 0, 0);
        chk(o_vic == 0 && o_ed == 1, "R8 dirty eviction", o_ed, 1);

        // R7: write-through allocation stays clean
        look(1, 6, 1, 1, 0);
        chk(o_fwd == 1, "R7 write-through forwarded", o_fwd, 1);
        fill_reads(6, 2, 7);
        look(9, 6, 0, 0, 0);
        chk(o_vic == 0 && o_ed == 0, "R7 write-through clean", o_ed, 0);

        // R7: copy-back write hit marks a clean line dirty
        look(1, 7, 0, 0, 0);
        look(1, 7, 1, 0, 0);
        fill_reads(7, 2, 7);
        look(9, 7, 0, 0, 0);
        chk(o_vic == 0 && o_ed == 1, "R7 hit marks dirty", o_ed, 1);

        // R9: snoop served alongside an unrelated core miss
        rv = 1; ra = mk(1, 8); rw = 0; rwt = 0; rtr = 0;
        sv = 1; sa = mk(4, 3); si = 0;
        step();
        chk(o_sh == 1 && o_sw == 3, "R9 parallel snoop", o_sw, 3);
        chk(o_hit == 0, "R9 core miss alongside", o_hit, 0);

        // R10: kill, then both ports miss
        rv = 0; sv = 1; sa = mk(4, 3); si = 1;
        step();
        rv = 1; ra = mk(4, 3); rw = 0; sv = 1; sa = mk(4, 3); si = 0;
        step();
        chk(o_hit == 0 && o_vic == 3, "R10 killed line refilled", o_vic, 3);
        chk(o_sh == 0, "R10 duplicate cleared", o_sh, 1);

        // R10: allocation beats a same-cycle kill of the same way
        fill_reads(9, 1, 8);
        rv = 1; ra = mk(20, 9); rw = 0; sv = 1; sa = mk(1, 9); si = 1;
        step();
        chk(o_vic == 0 && o_sh == 1 && o_sw == 0, "R10 collide setup", o_vic, 0);
        rv = 1; ra = mk(20, 9); sv = 1; sa = mk(1, 9); si = 0;
        step();
        chk(o_hit == 1 && o_way == 0, "R10 fill wins", o_way, 0);
        chk(o_sh == 0, "R10 old line gone", o_sh, 0);

        // R2: index and top tag bit separate lines
        look(3, 10, 0, 0, 0);
        look(3, 11, 0, 0, 0);
        chk(o_hit == 0, "R2 index distinct", o_hit, 0);
        look(3 | (1 << 19), 10, 0, 0, 0);
        chk(o_hit == 0, "R2 tag msb distinct", o_hit, 0);
        look(3, 10, 0, 0, 0);
        chk(o_hit == 1, "R2 original line kept", o_hit, 1);

        // random traffic on four sets
        void'($urandom(32'd2024));
        for (int n = 0; n < 4000; n++) begin
            int pool [4];
            pool = '{3, 9, 64, 127};
            rv  = ($urandom_range(99) < 85);
            ra  = mk($urandom_range(11), pool[$urandom_range(3)]);
            rw  = $urandom_range(1);
            rwt = $urandom_range(1);
            rtr = ($urandom_range(99) < 20);
            sv  = ($urandom_range(99) < 30);
            sa  = mk($urandom_range(11), pool[$urandom_range(3)]);
            si  = $urandom_range(1);
            step();
        end

        rv = 0; sv = 0;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule